// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the operand-steering and interlock logic for a five-stage in-order load/store pipeline (fetch, decode, execute, memory, write-back). It looks at the register numbers, write enables and load/store flags carried by the decode, execute, memory and write-back pipeline registers. From them it picks where each execute-stage operand comes from: the register file, the result still in the memory stage, or the result in the write-back stage. It also decides whether the store data arriving at the memory stage should be replaced by the word in write-back.

When a load in execute produces a register that the decode-stage instruction needs in execute, the block raises `stall` for one cycle. The surrounding pipeline then freezes the program counter and the decode register and clears the control bits entering execute. The parameter `MEM_ST_FWD` adds a write-back-to-memory path for store data. With that path, a store that only writes the word loaded by the instruction just before it runs without a bubble. A store that uses that word as its base address still stalls.

The datapath muxes, the register file and the memories sit outside this block. All outputs are combinational functions of the current stage fields.

Top module: `fwd_hazard_ctl`

## Requirements
- R1: Register 0 never causes a forward (`fwd_a`/`fwd_b` stay 0, `fwd_st` stays 0) and never causes a stall, even when a stage writes it.
- R2: Operand select encoding is 0 = register file, 2 = result in the memory stage, 1 = result in write-back. A stage is chosen when its destination equals the execute source register. A load sitting in the memory stage is never chosen. With all stage fields zero, every output is 0.
- R3: When both the memory-stage and write-back destinations match the same source register, the select is 2.
- R4: A stage whose write enable is low is never a forwarding source or a stall cause.
- R5: An ALU result followed directly by a store of that result does not stall. The store-data operand (`fwd_b`) selects 2 when the store is in execute.
- R6: A load followed directly by an instruction that reads the loaded register as an execute operand raises `stall`. After the bubble, that operand selects 1.
- R7: With `MEM_ST_FWD`=1, a load followed directly by a store whose data register (rs2) is the load's destination does not stall. When the store reaches memory with the load in write-back, `fwd_st` is 1.
- R8: A load followed directly by a store whose base register (rs1) is the load's destination raises `stall` in both configurations.
- R9: With `MEM_ST_FWD`=0, the load-then-store-data case of R7 raises `stall`, and `fwd_st` is always 0.
- R10: Each load-use pair stalls exactly one cycle. Once the bubble is in execute and the load is in memory, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst_n | input | 1 | Active-low reset |
| id_rs1 | input | REG_W | Decode-stage first source register (store base) |
| id_rs2 | input | REG_W | Decode-stage second source register (store data) |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | REG_W | Execute-stage first source register |
| ex_rs2 | input | REG_W | Execute-stage second source register |
| ex_rd | input | REG_W | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage register write enable |
| mem_is_load | input | 1 | Memory instruction is a load |
| mem_is_store | input | 1 | Memory instruction is a store |
| mem_rs2 | input | REG_W | Memory-stage store data register |
| wb_rd | input | REG_W | Write-back destination |
| wb_wen | input | 1 | Write-back register write enable |
| fwd_a | output | 2 | Select for execute operand A |
| fwd_b | output | 2 | Select for execute operand B / store data |
| fwd_st | output | 1 | Replace memory-stage store data with write-back word |
| stall | output | 1 | Freeze PC and decode register, bubble into execute |

## Verification
Every cycle, the embedded properties check these port relations: register 0 never forwards, a write enable gates forwarding, memory-stage priority holds, loads in memory are never selected, `fwd_st` only fires for a matching store, and a load hitting a base register stalls. They also check that a stall never lasts two cycles. Only the bench scenarios can show the timing across stages. That covers the bubble followed by a write-back forward, the store moving on to pick up the loaded word in memory, and the different stall outcome of the two configurations on the same instruction pair.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } opnd_src_e;
endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
   import hz_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] src_reg,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_is_load,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output opnd_src_e        sel
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   logic mem_hit, wb_hit;

   assign mem_hit = mem_wen && !mem_is_load && (mem_rd != ZERO_REG) && (mem_rd == src_reg);
   assign wb_hit  = wb_wen && (wb_rd != ZERO_REG) && (wb_rd == src_reg);

   always_comb begin
      if (mem_hit)     sel = SRC_MEM;
      else if (wb_hit) sel = SRC_WB;
      else             sel = SRC_RF;
   end

   // R1
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_reg == ZERO_REG) |-> (sel == SRC_RF));
   // R3
   mem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && !mem_is_load && wb_wen && src_reg != ZERO_REG &&
       mem_rd == src_reg && wb_rd == src_reg) |-> (sel == SRC_MEM));
   // R4
   wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wen && !wb_wen) |-> (sel == SRC_RF));
   // R2
   no_load_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_is_load |-> (sel != SRC_MEM));
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd #(
   parameter int REG_W      = 5,
   parameter bit MEM_ST_FWD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mem_is_store,
   input  logic [REG_W-1:0] mem_rs2,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic             fwd_st
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   generate
      if (MEM_ST_FWD) begin : g_path
         assign fwd_st = mem_is_store && wb_wen && (wb_rd != ZERO_REG) && (wb_rd == mem_rs2);
      end else begin : g_nopath
         assign fwd_st = 1'b0;
      end
   endgenerate

   // R7
   st_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_st |-> (mem_is_store && wb_wen));
   // R7
   st_reg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_st |-> (wb_rd == mem_rs2));
   // R1
   st_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rs2 == ZERO_REG) |-> !fwd_st);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_W      = 5,
   parameter bit MEM_ST_FWD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic             id_use_rs1,
   input  logic             id_use_rs2,
   input  logic             id_is_store,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_is_load,
   output logic             stall
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   logic ld_live, hit_a, hit_b, hit_b_eff;

   assign ld_live = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
   assign hit_a   = id_use_rs1 && (id_rs1 == ex_rd);
   assign hit_b   = id_use_rs2 && (id_rs2 == ex_rd);

   generate
      if (MEM_ST_FWD) begin : g_st_exempt
         assign hit_b_eff = hit_b && !id_is_store;
      end else begin : g_st_stall
         logic unused_st;
         assign unused_st = id_is_store;
         assign hit_b_eff = hit_b;
      end
   endgenerate

   assign stall = ld_live && (hit_a || hit_b_eff);

   // R10
   stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);
   // R6
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_is_load && ex_wen && ex_rd != ZERO_REG));
   // R8
   base_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && ex_wen && ex_rd != ZERO_REG && id_use_rs1 && id_rs1 == ex_rd) |-> stall);
endmodule

// File: rtl/fwd_hazard_ctl.sv
module fwd_hazard_ctl
   import hz_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit MEM_ST_FWD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic             id_use_rs1,
   input  logic             id_use_rs2,
   input  logic             id_is_store,
   input  logic [REG_W-1:0] ex_rs1,
   input  logic [REG_W-1:0] ex_rs2,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_is_load,
   input  logic             mem_is_store,
   input  logic [REG_W-1:0] mem_rs2,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b,
   output logic             fwd_st,
   output logic             stall
);
   localparam int N_OPND = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_w
         $error("REG_W must lie in 1..8");
      end
   endgenerate

   logic [REG_W-1:0] ex_src [N_OPND];
   opnd_src_e        sel    [N_OPND];

   assign ex_src[0] = ex_rs1;
   assign ex_src[1] = ex_rs2;

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         hz_opnd_sel #(.REG_W(REG_W)) u_sel (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_reg    (ex_src[g]),
            .mem_rd     (mem_rd),
            .mem_wen    (mem_wen),
            .mem_is_load(mem_is_load),
            .wb_rd      (wb_rd),
            .wb_wen     (wb_wen),
            .sel        (sel[g])
         );
      end
   endgenerate

   assign fwd_a = sel[0];
   assign fwd_b = sel[1];

   hz_store_fwd #(.REG_W(REG_W), .MEM_ST_FWD(MEM_ST_FWD)) u_st (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_is_store(mem_is_store),
      .mem_rs2     (mem_rs2),
      .wb_rd       (wb_rd),
      .wb_wen      (wb_wen),
      .fwd_st      (fwd_st)
   );

   hz_load_use #(.REG_W(REG_W), .MEM_ST_FWD(MEM_ST_FWD)) u_lu (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_rs1     (id_rs1),
      .id_rs2     (id_rs2),
      .id_use_rs1 (id_use_rs1),
      .id_use_rs2 (id_use_rs2),
      .id_is_store(id_is_store),
      .ex_rd      (ex_rd),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .stall      (stall)
   );
endmodule

// File: tb/sim_fwd_hazard_ctl.sv
`timescale 1ns/1ps
module sim_fwd_hazard_ctl;
   typedef struct packed {
      logic [4:0] rd, rs1, rs2;
      logic       wen, ld, st, u1, u2;
   } ins_t;

   localparam ins_t NOP = '0;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   ins_t s_id, s_ex, s_mem, s_wb;
   logic [1:0] fa0, fb0, fa1, fb1;
   logic       fs0, st0, fs1, st1;
   int n_chk = 0, n_bad = 0;

   fwd_hazard_ctl #(.REG_W(5), .MEM_ST_FWD(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(s_id.rs1), .id_rs2(s_id.rs2), .id_use_rs1(s_id.u1), .id_use_rs2(s_id.u2),
      .id_is_store(s_id.st),
      .ex_rs1(s_ex.rs1), .ex_rs2(s_ex.rs2), .ex_rd(s_ex.rd), .ex_wen(s_ex.wen), .ex_is_load(s_ex.ld),
      .mem_rd(s_mem.rd), .mem_wen(s_mem.wen), .mem_is_load(s_mem.ld), .mem_is_store(s_mem.st),
      .mem_rs2(s_mem.rs2), .wb_rd(s_wb.rd), .wb_wen(s_wb.wen),
      .fwd_a(fa0), .fwd_b(fb0), .fwd_st(fs0), .stall(st0));

   fwd_hazard_ctl #(.REG_W(5), .MEM_ST_FWD(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .id_rs1(s_id.rs1), .id_rs2(s_id.rs2), .id_use_rs1(s_id.u1), .id_use_rs2(s_id.u2),
      .id_is_store(s_id.st),
      .ex_rs1(s_ex.rs1), .ex_rs2(s_ex.rs2), .ex_rd(s_ex.rd), .ex_wen(s_ex.wen), .ex_is_load(s_ex.ld),
      .mem_rd(s_mem.rd), .mem_wen(s_mem.wen), .mem_is_load(s_mem.ld), .mem_is_store(s_mem.st),
      .mem_rs2(s_mem.rs2), .wb_rd(s_wb.rd), .wb_wen(s_wb.wen),
      .fwd_a(fa1), .fwd_b(fb1), .fwd_st(fs1), .stall(st1));

   function automatic ins_t alu(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
      ins_t i = NOP;
      i.rd = d; i.rs1 = a; i.rs2 = b; i.wen = 1'b1; i.u1 = 1'b1; i.u2 = 1'b1;
      return i;
   endfunction
   function automatic ins_t lw(input logic [4:0] d, input logic [4:0] base);
      ins_t i = NOP;
      i.rd = d; i.rs1 = base; i.wen = 1'b1; i.ld = 1'b1; i.u1 = 1'b1;
      return i;
   endfunction
   function automatic ins_t sw(input logic [4:0] data, input logic [4:0] base);
      ins_t i = NOP;
      i.rs1 = base; i.rs2 = data; i.st = 1'b1; i.u1 = 1'b1; i.u2 = 1'b1;
      return i;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_stages(input ins_t i_id, input ins_t i_ex, input ins_t i_mem, input ins_t i_wb);
      @(negedge clk);
      s_id = i_id; s_ex = i_ex; s_mem = i_mem; s_wb = i_wb;
      #2;
   endtask

   task automatic idle();
      set_stages(NOP, NOP, NOP, NOP);
   endtask

   task automatic t_reset();
      s_id = NOP; s_ex = NOP; s_mem = NOP; s_wb = NOP;
      #5;
      chk("R2 reset fwd_a", fa0, 0);
      chk("R2 reset fwd_b", fb0, 0);
      chk("R2 reset fwd_st", fs0, 0);
      chk("R2 reset stall", st0, 0);
   endtask

   task automatic t_alu_chain();
      idle();
      set_stages(NOP, alu(10, 3, 4), alu(3, 1, 1), alu(4, 1, 1));
      chk("R2 fwd_a from mem", fa0, 2);
      chk("R2 fwd_b from wb", fb0, 1);
      chk("R2 no stall", st0, 0);
   endtask

   task automatic t_priority();
      idle();
      set_stages(NOP, alu(10, 5, 5), alu(5, 1, 1), alu(5, 2, 2));
      chk("R3 mem over wb a", fa0, 2);
      chk("R3 mem over wb b", fb0, 2);
   endtask

   task automatic t_zero();
      idle();
      set_stages(alu(9, 0, 0), alu(10, 0, 0), alu(0, 1, 1), alu(0, 2, 2));
      chk("R1 r0 fwd_a", fa0, 0);
      chk("R1 r0 fwd_b", fb0, 0);
      idle();
      set_stages(alu(9, 0, 0), lw(0, 1), NOP, NOP);
      chk("R1 r0 load no stall", st0, 0);
      chk("R1 r0 load no stall cfg0", st1, 0);
   endtask

   task automatic t_wen();
      ins_t m = alu(6, 1, 1), w = alu(7, 1, 1), e = lw(8, 1);
      m.wen = 1'b0; w.wen = 1'b0; e.wen = 1'b0;
      idle();
      set_stages(alu(9, 8, 8), alu(10, 6, 7), m, w);
      chk("R4 no fwd a", fa0, 0);
      chk("R4 no fwd b", fb0, 0);
      idle();
      set_stages(alu(9, 8, 8), e, NOP, NOP);
      chk("R4 no stall", st0, 0);
   endtask

   task automatic t_alu_store();
      idle();
      set_stages(sw(9, 8), alu(9, 1, 2), NOP, NOP);
      chk("R5 alu->sw no stall", st0, 0);
      set_stages(NOP, sw(9, 8), alu(9, 1, 2), NOP);
      chk("R5 store data fwd", fb0, 2);
      chk("R5 base from rf", fa0, 0);
   endtask

   task automatic t_load_use();
      ins_t l = lw(7, 1), u = alu(11, 7, 2);
      idle();
      set_stages(u, l, NOP, NOP);
      chk("R6 load-use stall", st0, 1);
      chk("R6 load-use stall cfg0", st1, 1);
      set_stages(u, NOP, l, NOP);
      chk("R10 stall released", st0, 0);
      chk("R10 no mem fwd of load", fa0, 0);
      set_stages(NOP, u, NOP, l);
      chk("R6 wb fwd after bubble", fa0, 1);
      chk("R6 other operand rf", fb0, 0);
   endtask

   task automatic t_load_store();
      ins_t l = lw(7, 1), s = sw(7, 2);
      idle();
      set_stages(s, l, NOP, NOP);
      chk("R7 ld->sw data no stall", st0, 0);
      chk("R9 ld->sw data stalls cfg0", st1, 1);
      set_stages(NOP, s, l, NOP);
      chk("R7 load in mem not chosen", fb0, 0);
      set_stages(NOP, NOP, s, l);
      chk("R7 fwd_st wb->mem", fs0, 1);
      chk("R9 fwd_st off cfg0", fs1, 0);
   endtask

   task automatic t_load_base();
      idle();
      set_stages(sw(3, 6), lw(6, 1), NOP, NOP);
      chk("R8 base stall", st0, 1);
      chk("R8 base stall cfg0", st1, 1);
      idle();
      chk("R10 idle no stall", st0, 0);
   endtask

   initial begin
      #(20 * 5000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_alu_chain();
      t_priority();
      t_zero();
      t_wen();
      t_alu_store();
      t_load_use();
      t_load_store();
      t_load_base();
      idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule